// File: doc/BRIEF.md
# Dual-Pin Edge Interrupt Capture

This block watches two asynchronous interrupt pins, called A and B, and turns selected transitions on them into sticky interrupt requests. Each pin first passes through a synchroniser chain. A history flop then holds the previous synchronised sample, and an edge is the difference between the two. A single 2-bit select field decides which transitions count. Some codes make the two pins react to opposite polarities, and one code makes both pins react to every transition.

Requests from pin A appear on request line 2 and requests from pin B on request line 0. A request stays high until the priority logic or software clears it. The synchronised pin levels are always visible, so software can poll the pins without using the edge logic at all. The select field is written through a small write port. In the enclosing register map it sits in bits 7 and 6 of the request register, and the bus decoder presents those two bits on that port.

Top module: `pin_edge_irq`

## Requirements
- R1: After a synchronous active-low reset, every request output is 0, the select field is 00 and the synchronised levels read 1 (idle high).
- R2: `pin_level` shows pin A on bit 1 and pin B on bit 0, two clock edges after the pin changes, in every select mode.
- R3: With select 00, a falling edge on either pin raises its request and a rising edge raises none.
- R4: With select 01, pin A reacts only to falling edges and pin B only to rising edges.
- R5: With select 10, pin A reacts only to rising edges and pin B only to falling edges.
- R6: With select 11, both pins react to rising and to falling edges.
- R7: Pin A events drive request line 2 (`req_out[2]`), pin B events drive line 0 (`req_out[0]`); line 1 stays 0 and clearing it has no effect.
- R8: A raised request stays high until its `req_clr` bit is high at a clock edge, after which it reads 0.
- R9: When a new edge and a clear for the same line meet at the same clock edge, the request ends up high.
- R10: Writing the select field, with the pins held steady, raises no request. A pin change made earlier under a mode that ignored it is not reported later by a newly written mode. The new mode governs edges from the cycle after the write.
- R11: No request arises from the difference between the reset value of the synchronisers and the pin levels present when reset is released.
- R12: A qualifying pin change is set up before a clock edge. Its request reads high after the third rising clock edge, counted from that point, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 1 | Asynchronous interrupt pin A |
| pin_b | input | 1 | Asynchronous interrupt pin B |
| sel_we | input | 1 | Write strobe for the select field |
| sel_wdata | input | 2 | New select value (request register bits 7:6) |
| req_clr | input | REQ_LINES (3) | Per-line request clear |
| req_out | output | REQ_LINES (3) | Sticky request lines to the priority unit |
| pin_level | output | 2 | Synchronised pin levels, A on bit 1, B on bit 0 |

## Verification
The checker assumes that the pins may change at any time but stay stable for at least one clock period. Otherwise the two-sample comparison cannot be tied to a pin transition. It also assumes that the select field changes only through the write port. The bench drives every pin and control change at the falling clock edge, and it holds each level for several cycles. Each step of the table waits until the synchronisers and the history flop have settled before the step is checked. The arming window after reset is left undisturbed before any edge is expected.

// File: rtl/pin_edge_irq_pkg.sv
// Package: shared types for the dual-pin edge interrupt capture.
// Assumes pin A sits at index 1 and pin B at index 0 of every 2-bit pin vector.
package pin_edge_irq_pkg;

    localparam int NUM_PINS = 2;
    localparam int PIN_A    = 1;
    localparam int PIN_B    = 0;

    // Joint edge-sensitivity code for both pins (first word: pin A, second: pin B).
    typedef enum logic [1:0] {
        SEL_FALL_FALL = 2'b00,
        SEL_FALL_RISE = 2'b01,
        SEL_RISE_FALL = 2'b10,
        SEL_ANY_ANY   = 2'b11
    } edge_sel_e;

    // Per-pin enables derived from the select code.
    typedef struct packed {
        logic [NUM_PINS-1:0] rise_en;
        logic [NUM_PINS-1:0] fall_en;
    } edge_en_t;

    // Expand the joint select code into per-pin rise/fall enables.
    function automatic edge_en_t decode_sel(edge_sel_e s);
        edge_en_t e;
        e = '0;
        case (s)
            SEL_FALL_FALL: begin
                e.fall_en[PIN_A] = 1'b1;
                e.fall_en[PIN_B] = 1'b1;
            end
            SEL_FALL_RISE: begin
                e.fall_en[PIN_A] = 1'b1;
                e.rise_en[PIN_B] = 1'b1;
            end
            SEL_RISE_FALL: begin
                e.rise_en[PIN_A] = 1'b1;
                e.fall_en[PIN_B] = 1'b1;
            end
            default: begin
                e.rise_en = '1;
                e.fall_en = '1;
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pin_edge_irq_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; resets every stage to RESET_VAL.
module pin_edge_irq_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pin_edge_irq_detect.sv
// Module: edge detector comparing the current synchronised level with the previous one.
// Assumes lvl is already synchronous; the history always follows lvl, whatever enables are set.
module pin_edge_irq_detect #(
    parameter int               WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] hist_q;

    // History: previous synchronised sample, updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= RESET_VAL;
        else        hist_q <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_pin
            logic rose;
            logic fell;
            assign rose   = lvl[g] & ~hist_q[g];
            assign fell   = ~lvl[g] & hist_q[g];
            assign hit[g] = arm & ((rise_en[g] & rose) | (fall_en[g] & fell));
        end
    endgenerate

endmodule

// File: rtl/pin_edge_irq_req.sv
// Module: bank of sticky request flops with per-line set and clear.
// Assumes set and clear are synchronous pulses; set has priority over clear.
module pin_edge_irq_req #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] req
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            // Request flop: set wins, otherwise clear, otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n)      req[g] <= 1'b0;
                else if (set[g]) req[g] <= 1'b1;
                else if (clr[g]) req[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/pin_edge_irq.sv
// Module: dual-pin edge interrupt capture (top).
// Synchronises pins A and B, detects the edges chosen by a 2-bit joint select code
// and raises sticky requests on fixed lines. Assumes the select field is written
// only through sel_we/sel_wdata, and that pins idle high.
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter int REQ_LINES   = 3,
    parameter int LINE_A      = 2,
    parameter int LINE_B      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_a,
    input  logic                 pin_b,
    input  logic                 sel_we,
    input  logic [1:0]           sel_wdata,
    input  logic [REQ_LINES-1:0] req_clr,
    output logic [REQ_LINES-1:0] req_out,
    output logic [1:0]           pin_level
);

    localparam logic [NUM_PINS-1:0] IDLE_LEVEL = '1;
    localparam int ARM_CYC = SYNC_STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CYC + 1);

    edge_sel_e           sel_q;
    edge_en_t            en;
    logic [NUM_PINS-1:0] raw_pins;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] hit;
    logic [REQ_LINES-1:0] set_vec;
    logic [CNT_W-1:0]    arm_cnt;
    logic                armed;

    // Select register: holds the joint edge code.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SEL_FALL_FALL;
        else if (sel_we) sel_q <= edge_sel_e'(sel_wdata);
    end

    // Arming counter: blocks detection until synchroniser and history hold real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_cnt <= '0;
        else if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end

    assign armed = (arm_cnt == CNT_W'(ARM_CYC));

    assign raw_pins[PIN_A] = pin_a;
    assign raw_pins[PIN_B] = pin_b;
    assign en = decode_sel(sel_q);

    pin_edge_irq_sync #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (sync_lvl)
    );

    pin_edge_irq_detect #(
        .WIDTH     (NUM_PINS),
        .RESET_VAL (IDLE_LEVEL)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (armed),
        .lvl     (sync_lvl),
        .rise_en (en.rise_en),
        .fall_en (en.fall_en),
        .hit     (hit)
    );

    // Routing: pin A events to LINE_A, pin B events to LINE_B, others idle.
    always_comb begin
        set_vec         = '0;
        set_vec[LINE_A] = hit[PIN_A];
        set_vec[LINE_B] = hit[PIN_B];
    end

    pin_edge_irq_req #(
        .LINES (REQ_LINES)
    ) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (req_clr),
        .req   (req_out)
    );

    assign pin_level = sync_lvl;

endmodule

// File: rtl/pin_edge_irq_chk.sv
// Module: property checker for pin_edge_irq, attached by bind.
// Assumes pins are stable for at least one clock and the select changes only via the write port.
module pin_edge_irq_chk #(
    parameter int N      = 3,
    parameter int LINE_A = 2,
    parameter int LINE_B = 0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   pins,
    input logic [1:0]   pin_level,
    input logic [1:0]   sel,
    input logic         armed,
    input logic [1:0]   hit,
    input logic [N-1:0] req_clr,
    input logic [N-1:0] req
);

    localparam logic [N-1:0] LINE_MASK = (N'(1) << LINE_A) | (N'(1) << LINE_B);

    logic [1:0] cyc;

    // Cycles since reset, saturating, to guard $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (pin_level == $past(pins, 2))); // R2
    AST_MODE00_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && hit != 2'b00) |-> ((hit & pin_level) == 2'b00)); // R3
    AST_MODE01_A_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && hit[1]) |-> !pin_level[1]); // R4
    AST_MODE01_B_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && hit[0]) |-> pin_level[0]); // R4
    AST_MODE10_A_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && hit[1]) |-> pin_level[1]); // R5
    AST_MODE10_B_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && hit[0]) |-> !pin_level[0]); // R5
    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != 2'b00) |-> ((hit & (pin_level ^ $past(pin_level))) == hit)); // R6
    AST_SPARE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & ~LINE_MASK) == '0)); // R7
    AST_REQ_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req[LINE_A]) && !$past(req_clr[LINE_A])) |-> req[LINE_A]); // R8
    AST_CLR_A_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_clr[LINE_A]) && !$past(hit[1])) |-> !req[LINE_A]); // R8
    AST_HIT_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> req[LINE_A]); // R9
    AST_HIT_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> req[LINE_B]); // R9
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (hit == 2'b00)); // R11

endmodule

bind pin_edge_irq pin_edge_irq_chk #(
    .N      (REQ_LINES),
    .LINE_A (LINE_A),
    .LINE_B (LINE_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (raw_pins),
    .pin_level (pin_level),
    .sel       (sel_q),
    .armed     (armed),
    .hit       (hit),
    .req_clr   (req_clr),
    .req       (req_out)
);

// File: tb/pin_edge_irq_bench.sv
// Bench: table-driven mode checks followed by directed reset and corner-case tests.
module pin_edge_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_a = 1'b1;
    logic       pin_b = 1'b1;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic [2:0] req_clr = 3'b000;
    logic [2:0] req_out;
    logic [1:0] pin_level;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pin_edge_irq u_pin_edge_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_a     (pin_a),
        .pin_b     (pin_b),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .req_clr   (req_clr),
        .req_out   (req_out),
        .pin_level (pin_level)
    );

    // {sel[8:7], a_before, b_before, a_after, b_after, expected req[2:0]}
    localparam logic [8:0] VEC [12] = '{
        9'b00_0011_000, 9'b00_1100_101, 9'b00_0110_001,
        9'b01_0011_001, 9'b01_1100_100, 9'b01_0110_000,
        9'b10_0011_100, 9'b10_1100_001, 9'b10_0110_101,
        9'b11_0011_101, 9'b11_1100_101, 9'b11_0110_101
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_sel(input logic [1:0] code);
        sel_we = 1'b1;
        sel_wdata = code;
        cyc(1);
        sel_we = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        req_clr = m;
        cyc(1);
        req_clr = 3'b000;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tag;
        @(negedge clk);
        do_reset();
        chk("R1 req after reset", {5'b0, req_out}, 8'h00);
        chk("R1 level after reset", {6'b0, pin_level}, 8'h03);
        cyc(6);

        // Mode table (R3..R6, routing R7).
        for (int i = 0; i < 12; i++) begin
            logic [8:0] v;
            v = VEC[i];
            case (v[8:7])
                2'b00:   tag = "R3 R7 mode 00";
                2'b01:   tag = "R4 R7 mode 01";
                2'b10:   tag = "R5 R7 mode 10";
                default: tag = "R6 R7 mode 11";
            endcase
            pin_a = v[6];
            pin_b = v[5];
            wr_sel(v[8:7]);
            cyc(5);
            clr(3'b111);
            pin_a = v[4];
            pin_b = v[3];
            cyc(5);
            chk(tag, {5'b0, req_out}, {5'b0, v[2:0]});
            chk("R2 level in table", {6'b0, pin_level}, {6'b0, v[4], v[3]});
        end

        // Reset state and default mode with pins idle high.
        pin_a = 1'b1;
        pin_b = 1'b1;
        do_reset();
        chk("R1 req after second reset", {5'b0, req_out}, 8'h00);
        cyc(5);
        chk("R11 idle-high pins quiet", {5'b0, req_out}, 8'h00);

        // Latency and level delay on pin A falling (R12, R2).
        pin_a = 1'b0;
        cyc(1);
        chk("R2 level not yet moved", {7'b0, pin_level[1]}, 8'h01);
        cyc(1);
        chk("R2 level after two edges", {7'b0, pin_level[1]}, 8'h00);
        chk("R12 no request after two edges", {5'b0, req_out}, 8'h00);
        cyc(1);
        chk("R12 request after third edge", {5'b0, req_out}, 8'h04);

        // Sticky and clear behaviour (R8, R7).
        cyc(10);
        chk("R8 request held", {5'b0, req_out}, 8'h04);
        clr(3'b010);
        chk("R7 clearing line 1 no effect", {5'b0, req_out}, 8'h04);
        clr(3'b100);
        chk("R8 clear drops line 2", {5'b0, req_out}, 8'h00);

        // Set beats clear on pin B (R9).
        pin_b = 1'b0;
        cyc(2);
        req_clr = 3'b001;
        cyc(1);
        req_clr = 3'b000;
        chk("R9 set wins over clear", {5'b0, req_out}, 8'h01);
        clr(3'b111);

        // Mode writes create no request; history keeps tracking (R10).
        pin_a = 1'b1;
        cyc(5);
        chk("R3 rising ignored in mode 00", {5'b0, req_out}, 8'h00);
        wr_sel(2'b10);
        cyc(5);
        chk("R10 switch to 10 after rise", {5'b0, req_out}, 8'h00);
        wr_sel(2'b01);
        cyc(3);
        chk("R10 switch to 01", {5'b0, req_out}, 8'h00);
        wr_sel(2'b11);
        cyc(3);
        chk("R10 switch to 11", {5'b0, req_out}, 8'h00);
        wr_sel(2'b00);
        cyc(3);
        chk("R10 switch to 00", {5'b0, req_out}, 8'h00);
        pin_a = 1'b0;
        cyc(5);
        chk("R10 new mode governs edges", {5'b0, req_out}, 8'h04);
        clr(3'b111);

        // Pins low across reset: no false falling edge (R11).
        pin_a = 1'b0;
        pin_b = 1'b0;
        do_reset();
        cyc(6);
        chk("R11 no request after reset release", {5'b0, req_out}, 8'h00);
        chk("R2 level low after reset", {6'b0, pin_level}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule